// File: doc/BRIEF.md
# Single-Bit Boolean Processor Unit

This unit carries out single-bit operations on a byte-organised internal data space and keeps the carry flag, which works as a one-bit accumulator for Boolean logic. A caller supplies an operation code and an 8-bit bit address on a one-cycle `start` pulse. The unit turns the bit address into a byte address and a bit position, reads that byte through a synchronous memory port, and computes the new carry and the new bit. Where a bit changes, it writes the whole byte back with the other seven bits kept as they were read.

The bit space is split in two halves. The lower half covers a sixteen-byte RAM window. The upper half covers register bytes whose address is a multiple of eight. For the bit-test operations, `branch_taken` reports the outcome in the cycle that `done` is high. Target addresses are left to the instruction sequencer. The carry flag is also reachable as bit address D7h, and a separate write port lets status-word logic load it directly.

Top module: `bitproc_unit`

## Requirements
- R1: Bit addresses 00h-7Fh select byte 20h + (address >> 3) at bit position address[2:0] (e.g. 00h gives byte 20h bit 0, 7Fh gives byte 2Fh bit 7).
- R2: Bit addresses 80h-FFh select byte (address with bits [2:0] cleared) at bit position address[2:0] (e.g. F3h gives byte F0h bit 3).
- R3: Carry logic ops with bit value b: op 0 sets C=C&b, op 1 sets C=C&~b, op 2 sets C=C|b, op 3 sets C=C|~b, op 4 sets C=b; none of them writes memory.
- R4: Bit write ops: op 5 stores C into the bit, op 9 clears it, op 10 sets it, op 11 inverts it. Each writes the addressed byte back with exactly that bit replaced and the other seven bits unchanged.
- R5: Carry-only ops (op 6 clear C, op 7 set C, op 8 invert C) make no memory access and raise `done` in the first cycle after `start` is sampled.
- R6: Branch ops raise `branch_taken` together with `done` when the condition holds: op 12 C=1, op 13 C=0, op 14 b=1, op 15 b=0. For all other ops `branch_taken` stays low.
- R7: Op 16 is taken when b=1 and then writes the byte back with that bit cleared. When b=0 it is not taken and makes no memory write.
- R8: Bit address D7h maps to the carry register: the bit value read is the current carry, and a bit write updates the carry and also writes the new value to byte D0h bit 7.
- R9: Ops that touch memory assert `mem_rd_en` for one cycle in the cycle after `start` is sampled. `done` follows in the next cycle, with any write in that same cycle. `done` is a one-cycle pulse.
- R10: `cy_wr_en` loads `cy_wr_val` into the carry at the next clock. When an operation updates the carry at the same clock edge, the operation's value wins.
- R11: `start` is ignored while an operation is in progress, up to and including its `done` cycle.
- R12: Op codes 17-31 raise `done` one cycle after `start`, with no memory access, no carry change and `branch_taken` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_code | input | 5 | Operation code |
| bit_addr | input | 8 | Bit address |
| mem_addr | output | 8 | Byte address for read and write |
| mem_rd_en | output | 1 | Read request, data returned one cycle later |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte write data (merged) |
| cy_wr_en | input | 1 | External carry load |
| cy_wr_val | input | 1 | External carry value |
| carry | output | 1 | Current carry flag |
| done | output | 1 | Operation complete |
| branch_taken | output | 1 | Branch condition met, valid with done |

## Verification
On every cycle, the assertions check that a read is always followed by `done` and that `done` never lasts two cycles. They also check that a write changes at most one bit of the byte read and stays at the same address, that `branch_taken` appears only with `done`, and that the carry moves only on a `done` or an external load. The correctness of each operation's result, the address mapping for both halves of the space, the carry substitution at D7h, the priority between the two carry writers and the ignoring of `start` while busy all depend on data values. Only the bench scenarios can show these, by comparing against a reference byte space.

// File: rtl/bitproc_pkg.sv
// Shared types for the Boolean bit processor.
// Assumes 5-bit operation codes; unlisted codes are treated as no-ops.
package bitproc_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ANL_C    = 5'd0,
        OP_ANL_NC   = 5'd1,
        OP_ORL_C    = 5'd2,
        OP_ORL_NC   = 5'd3,
        OP_LD_C     = 5'd4,
        OP_ST_C     = 5'd5,
        OP_CLR_C    = 5'd6,
        OP_SET_C    = 5'd7,
        OP_CPL_C    = 5'd8,
        OP_CLR_B    = 5'd9,
        OP_SET_B    = 5'd10,
        OP_CPL_B    = 5'd11,
        OP_JMP_C    = 5'd12,
        OP_JMP_NC   = 5'd13,
        OP_JMP_B    = 5'd14,
        OP_JMP_NB   = 5'd15,
        OP_JMP_BCLR = 5'd16
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EXEC = 2'd2
    } bstate_e;

    typedef struct packed {
        logic new_cy;
        logic cy_we;
        logic new_bit;
        logic bit_we;
        logic taken;
    } alu_res_t;

    // Returns 1 when the operation needs the addressed byte.
    function automatic logic op_uses_mem(input logic [OP_W-1:0] op);
        case (op)
            OP_ANL_C, OP_ANL_NC, OP_ORL_C, OP_ORL_NC, OP_LD_C, OP_ST_C,
            OP_CLR_B, OP_SET_B, OP_CPL_B,
            OP_JMP_B, OP_JMP_NB, OP_JMP_BCLR: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
// Bit-address decoder: splits a bit address into byte address and bit position.
// Lower half indexes a RAM window at RAM_BASE; upper half indexes register
// bytes whose low address bits are zero. Assumes BYTE_W is a power of two.
module bitproc_addr_map #(
    parameter int                ADDR_W   = 8,
    parameter int                BYTE_W   = 8,
    parameter logic [ADDR_W-1:0] RAM_BASE = 8'h20
) (
    input  logic [ADDR_W-1:0]         bit_addr,
    output logic [ADDR_W-1:0]         byte_addr,
    output logic [$clog2(BYTE_W)-1:0] bit_pos
);
    localparam int POS_W = $clog2(BYTE_W);

    // Choose the byte according to which half of the bit space is addressed.
    always_comb begin
        bit_pos = bit_addr[POS_W-1:0];
        if (bit_addr[ADDR_W-1])
            byte_addr = {bit_addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        else
            byte_addr = RAM_BASE + (bit_addr >> POS_W);
    end
endmodule

// File: rtl/bitproc_alu.sv
// Single-bit operation unit: given the op, the carry and the addressed bit,
// produces the new carry, the new bit, their write enables and branch outcome.
// Purely combinational; unknown op codes produce no effect.
module bitproc_alu
    import bitproc_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            cy,
    input  logic            bval,
    output alu_res_t        res
);
    // Evaluate the operation.
    always_comb begin
        res = '0;
        case (op)
            OP_ANL_C:  begin res.new_cy = cy & bval;  res.cy_we = 1'b1; end
            OP_ANL_NC: begin res.new_cy = cy & ~bval; res.cy_we = 1'b1; end
            OP_ORL_C:  begin res.new_cy = cy | bval;  res.cy_we = 1'b1; end
            OP_ORL_NC: begin res.new_cy = cy | ~bval; res.cy_we = 1'b1; end
            OP_LD_C:   begin res.new_cy = bval;       res.cy_we = 1'b1; end
            OP_ST_C:   begin res.new_bit = cy;        res.bit_we = 1'b1; end
            OP_CLR_C:  begin res.new_cy = 1'b0;       res.cy_we = 1'b1; end
            OP_SET_C:  begin res.new_cy = 1'b1;       res.cy_we = 1'b1; end
            OP_CPL_C:  begin res.new_cy = ~cy;        res.cy_we = 1'b1; end
            OP_CLR_B:  begin res.new_bit = 1'b0;      res.bit_we = 1'b1; end
            OP_SET_B:  begin res.new_bit = 1'b1;      res.bit_we = 1'b1; end
            OP_CPL_B:  begin res.new_bit = ~bval;     res.bit_we = 1'b1; end
            OP_JMP_C:  res.taken = cy;
            OP_JMP_NC: res.taken = ~cy;
            OP_JMP_B:  res.taken = bval;
            OP_JMP_NB: res.taken = ~bval;
            OP_JMP_BCLR: begin
                res.taken   = bval;
                res.new_bit = 1'b0;
                res.bit_we  = bval;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bitproc_ctrl.sv
// Sequencer: accepts start when idle, latches op and bit address, and steps
// through a read phase (memory ops only) and an execute phase of one cycle.
// Assumes the byte port returns read data one cycle after the request.
module bitproc_ctrl
    import bitproc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [OP_W-1:0]   op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rd_phase,
    output logic              exec_phase
);
    bstate_e state;

    // Advance the operation state and capture the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    op_q   <= op_in;
                    addr_q <= addr_in;
                    state  <= op_uses_mem(op_in) ? ST_READ : ST_EXEC;
                end
                ST_READ: state <= ST_EXEC;
                ST_EXEC: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase flags for the datapath.
    always_comb begin
        rd_phase   = (state == ST_READ);
        exec_phase = (state == ST_EXEC);
    end
endmodule

// File: rtl/bitproc_unit.sv
// Boolean bit processor top: sequences a read-modify-write of one bit in the
// byte space and keeps the carry flag. The carry's own bit address reads and
// writes the carry register. Assumes a synchronous byte port, one-cycle read.
module bitproc_unit
    import bitproc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                BYTE_W      = 8,
    parameter logic [ADDR_W-1:0] RAM_BASE    = 8'h20,
    parameter logic [ADDR_W-1:0] CY_BIT_ADDR = 8'hD7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_code,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              cy_wr_en,
    input  logic              cy_wr_val,
    output logic              carry,
    output logic              done,
    output logic              branch_taken
);
    localparam int POS_W = $clog2(BYTE_W);

    logic [OP_W-1:0]   op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_phase;
    logic              exec_phase;
    logic [ADDR_W-1:0] byte_addr;
    logic [POS_W-1:0]  bit_pos;
    logic              cy_q;
    logic              is_cy_addr;
    logic              bval;
    alu_res_t          res;

    bitproc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op_in      (op_code),
        .addr_in    (bit_addr),
        .op_q       (op_q),
        .addr_q     (addr_q),
        .rd_phase   (rd_phase),
        .exec_phase (exec_phase)
    );

    bitproc_addr_map #(
        .ADDR_W   (ADDR_W),
        .BYTE_W   (BYTE_W),
        .RAM_BASE (RAM_BASE)
    ) u_map (
        .bit_addr  (addr_q),
        .byte_addr (byte_addr),
        .bit_pos   (bit_pos)
    );

    // Select the operand bit, substituting the carry at its own address.
    always_comb begin
        is_cy_addr = (addr_q == CY_BIT_ADDR);
        bval       = is_cy_addr ? cy_q : mem_rdata[bit_pos];
    end

    bitproc_alu u_alu (
        .op   (op_q),
        .cy   (cy_q),
        .bval (bval),
        .res  (res)
    );

    // Drive the byte port; write data is the read byte with one bit replaced.
    always_comb begin
        mem_addr           = byte_addr;
        mem_rd_en          = rd_phase;
        mem_wr_en          = exec_phase & res.bit_we;
        mem_wdata          = mem_rdata;
        mem_wdata[bit_pos] = res.new_bit;
    end

    // Update the carry: operation result first, then bit alias, then external load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cy_q <= 1'b0;
        else if (exec_phase && res.cy_we)
            cy_q <= res.new_cy;
        else if (exec_phase && res.bit_we && is_cy_addr)
            cy_q <= res.new_bit;
        else if (cy_wr_en)
            cy_q <= cy_wr_val;
    end

    // Completion and branch outputs.
    always_comb begin
        carry        = cy_q;
        done         = exec_phase;
        branch_taken = exec_phase & res.taken;
    end
endmodule

// File: rtl/bitproc_unit_chk.sv
// Protocol checker for bitproc_unit, attached with bind. Observes ports only.
module bitproc_unit_chk #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd_en,
    input logic [BYTE_W-1:0] mem_rdata,
    input logic              mem_wr_en,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              cy_wr_en,
    input logic              carry,
    input logic              done,
    input logic              branch_taken
);
    a_r9_read_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> done);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_read_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !done);

    a_r4_write_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) <= 1));

    a_r4_write_same_byte: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $stable(mem_addr));

    a_r4_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> done);

    a_r6_taken_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken |-> done);

    a_r10_carry_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(done || cy_wr_en) |=> $stable(carry));
endmodule

bind bitproc_unit bitproc_unit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_addr     (mem_addr),
    .mem_rd_en    (mem_rd_en),
    .mem_rdata    (mem_rdata),
    .mem_wr_en    (mem_wr_en),
    .mem_wdata    (mem_wdata),
    .cy_wr_en     (cy_wr_en),
    .carry        (carry),
    .done         (done),
    .branch_taken (branch_taken)
);

// File: tb/bitproc_unit_tb.sv
// Self-checking bench: byte-space model plus independent reference prediction.
module bitproc_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] bit_addr = '0;
    logic [7:0] mem_addr;
    logic       mem_rd_en;
    logic [7:0] mem_rdata = '0;
    logic       mem_wr_en;
    logic [7:0] mem_wdata;
    logic       cy_wr_en = 1'b0;
    logic       cy_wr_val = 1'b0;
    logic       carry;
    logic       done;
    logic       branch_taken;

    int n_checks = 0;
    int n_errors = 0;
    int rd_cnt = 0;

    logic [7:0] mem_model [256];
    logic [7:0] ref_mem [256];
    logic       ref_cy = 1'b0;

    always #2 clk = ~clk;

    bitproc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .bit_addr(bit_addr), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
        .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .cy_wr_en(cy_wr_en), .cy_wr_val(cy_wr_val), .carry(carry),
        .done(done), .branch_taken(branch_taken)
    );

    // Byte-space model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_model[mem_addr];
        if (mem_wr_en) mem_model[mem_addr] <= mem_wdata;
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input logic [7:0] a);
        return a[7] ? {a[7:3], 3'b000} : (8'h20 + {3'b000, a[7:3]});
    endfunction

    function automatic logic ref_uses_mem(input logic [4:0] o);
        return (o <= 5) || (o >= 9 && o <= 11) || (o >= 14 && o <= 16);
    endfunction

    // Prediction {new_cy, cy_we, new_bit, bit_we, taken}.
    function automatic logic [4:0] predict(input logic [4:0] o, input logic c, input logic b);
        case (o)
            5'd0:  return {c & b, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd1:  return {c & ~b, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd2:  return {c | b, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd3:  return {c | ~b, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd4:  return {b, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd5:  return {1'b0, 1'b0, c, 1'b1, 1'b0};
            5'd6:  return {1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd7:  return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd8:  return {~c, 1'b1, 1'b0, 1'b0, 1'b0};
            5'd9:  return {1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
            5'd10: return {1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
            5'd11: return {1'b0, 1'b0, ~b, 1'b1, 1'b0};
            5'd12: return {4'b0, c};
            5'd13: return {4'b0, ~c};
            5'd14: return {4'b0, b};
            5'd15: return {4'b0, ~b};
            5'd16: return {2'b00, 1'b0, b, b};
            default: return 5'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] o, input logic [7:0] a);
        if (a == 8'hD7 && ref_uses_mem(o)) return "R8";
        if (o <= 4) return "R3";
        if (o == 5 || (o >= 9 && o <= 11)) return "R4";
        if (o >= 6 && o <= 8) return "R5";
        if (o >= 12 && o <= 15) return "R6";
        if (o == 16) return "R7";
        return "R12";
    endfunction

    // Run one operation and check it; inject: extra start while busy (R11);
    // ext: external carry load in the done cycle (R10).
    task automatic do_op(input logic [4:0] o, input logic [7:0] a,
                         input logic inject, input logic ext, input logic ext_val);
        logic [7:0] by = ref_byte(a);
        logic [2:0] pos = a[2:0];
        logic       is_cy = (a == 8'hD7);
        logic       b = is_cy ? ref_cy : ref_mem[by][pos];
        logic [4:0] p = predict(o, ref_cy, b);
        logic [7:0] exp_byte = ref_mem[by];
        int         exp_lat = ref_uses_mem(o) ? 2 : 1;
        int         cyc;
        string      t = tag_of(o, a);
        exp_byte[pos] = p[2];
        @(negedge clk);
        rd_cnt = 0;
        start = 1'b1; op_code = o; bit_addr = a;
        @(negedge clk);
        start = inject; op_code = 5'd8; bit_addr = 8'h00;
        cyc = 1;
        while (!done && cyc < 6) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        start = 1'b0;
        chk(cyc == exp_lat, {t, "/R9 latency"}, cyc, exp_lat);
        chk(branch_taken == p[0], {t, " taken"}, branch_taken, p[0]);
        chk(mem_wr_en == p[1], {t, " write"}, mem_wr_en, p[1]);
        if (p[1]) begin
            chk(mem_addr == by, {t, "/R1/R2 addr"}, mem_addr, by);
            chk(mem_wdata == exp_byte, {t, " wdata"}, mem_wdata, exp_byte);
            ref_mem[by] = exp_byte;
        end
        cy_wr_en = ext; cy_wr_val = ext_val;
        if (p[3]) ref_cy = p[4];
        else if (p[1] && is_cy) ref_cy = p[2];
        else if (ext) ref_cy = ext_val;
        @(negedge clk);
        cy_wr_en = 1'b0;
        chk(carry == ref_cy, {t, "/R10 carry"}, carry, ref_cy);
        chk(mem_model[by] == ref_mem[by], {t, " byte"}, mem_model[by], ref_mem[by]);
        chk(rd_cnt == (ref_uses_mem(o) ? 1 : 0), {t, "/R5/R12 reads"}, rd_cnt, ref_uses_mem(o));
    endtask

    initial begin
        void'($urandom(32'd7321));
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = 8'($urandom);
            ref_mem[i]   = mem_model[i];
        end
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "reset outputs", done, 0);
        chk(carry == 1'b0, "reset carry", carry, 0);
        rst_n = 1'b1;

        // R1 lower-half mapping corners
        do_op(5'd10, 8'h00, 0, 0, 0);
        do_op(5'd9,  8'h7F, 0, 0, 0);
        do_op(5'd11, 8'h35, 0, 0, 0);
        // R2 upper-half mapping
        do_op(5'd10, 8'h80, 0, 0, 0);
        do_op(5'd11, 8'hF3, 0, 0, 0);
        do_op(5'd9,  8'hE7, 0, 0, 0);
        // R3 carry logic, R5 carry-only
        do_op(5'd7, 8'h00, 0, 0, 0);
        do_op(5'd0, 8'h80, 0, 0, 0);
        do_op(5'd3, 8'h7F, 0, 0, 0);
        do_op(5'd4, 8'h00, 0, 0, 0);
        do_op(5'd8, 8'h00, 0, 0, 0);
        do_op(5'd6, 8'h00, 0, 0, 0);
        // R8 carry bit address
        do_op(5'd10, 8'hD7, 0, 0, 0);
        do_op(5'd12, 8'h00, 0, 0, 0);
        do_op(5'd11, 8'hD7, 0, 0, 0);
        do_op(5'd13, 8'h00, 0, 0, 0);
        // R7 branch-and-clear, set then clear
        do_op(5'd10, 8'h42, 0, 0, 0);
        do_op(5'd16, 8'h42, 0, 0, 0);
        do_op(5'd16, 8'h42, 0, 0, 0);
        // R12 undefined codes
        do_op(5'd20, 8'h10, 0, 0, 0);
        do_op(5'd31, 8'hD7, 0, 0, 0);
        // R11 start while busy, memory and carry-only ops
        do_op(5'd10, 8'h21, 1, 0, 0);
        do_op(5'd7,  8'h00, 1, 0, 0);
        // R10 external load alone and against an op carry update
        do_op(5'd14, 8'h21, 0, 1, 1'b0);
        do_op(5'd14, 8'h21, 0, 1, 1'b1);
        do_op(5'd6,  8'h00, 0, 1, 1'b1);
        do_op(5'd4,  8'h80, 0, 1, ~ref_mem[8'h80][0]);

        // Constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic [4:0] o = 5'($urandom_range(0, 18));
            logic [7:0] a = ($urandom_range(0, 7) == 0) ? 8'hD7 : 8'($urandom);
            do_op(o, a, 1'($urandom_range(0, 5) == 0),
                  1'($urandom_range(0, 5) == 0), 1'($urandom));
        end

        begin
            int mism = 0;
            for (int i = 0; i < 256; i++)
                if (mem_model[i] != ref_mem[i]) mism++;
            chk(mism == 0, "R4 whole byte space", mism, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule